// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Unit

This unit watches six external input pins and turns chosen level transitions on them into interrupt events for a downstream interrupt controller. Every pin carries a 2-bit mode that selects no detection, rising transitions, falling transitions or both. Pins 0 to 2 each drive their own one-cycle event output. Pins 3 to 5 form a shared group: each of them records its transitions in its own sticky flag bit, and the group has a single event line.

Software configures the unit through a small register port. There are two mode registers, one for the dedicated pins and one for the shared pins, and a flag register for the shared group. The flag bits are never cleared by hardware. Software clears a flag by writing 0 to its bit; writing 1 to a bit leaves it unchanged. Every pin passes through a synchronizer before its transitions are detected, so the pins may be fully asynchronous to the clock.

Top module: `edgeirq_unit`

## Requirements
- R1: After reset every register reads 00h and no event output is high.
- R2: A pin whose mode is 00 produces no event and sets no flag, whatever its level does.
- R3: Mode 01 detects rising transitions. A new pin level that is set up before clock edge E1 gives a dedicated event that is high only in the cycle after edge E3, two edges after E1.
- R4: Mode 10 detects falling transitions only.
- R5: Mode 11 detects both rising and falling transitions.
- R6: Register map on addr_i. Address 0 holds the dedicated-pin modes and address 1 the shared-pin modes; pin k of a group uses bits 2k+1:2k, and bits 7:6 read as 0. Address 2 holds the shared flags in bits 2:0, and bits 7:3 read as 0. Address 3 reads 00h and ignores writes.
- R7: A detected transition on shared pin 3+j sets flag bit j. The bit stays set until software clears it.
- R8: shr_evt_o pulses for one cycle whenever a flag bit goes from 0 to 1. A transition on a pin whose flag is already set gives no pulse.
- R9: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R10: A transition on a shared pin that is detected in the same cycle as a write of 0 to that pin's flag bit is lost. The flag ends up cleared and no shared event is produced.
- R11: The pin history updates even while the mode is 00. Changing a mode while the pin is steady produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | External pins; 2:0 dedicated, 5:3 shared |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for the register at addr_i |
| ded_evt_o | output | 3 | One-cycle events, one per dedicated pin |
| shr_evt_o | output | 1 | One-cycle event for the shared group |

## Verification
The hardest case to reach from the ports is the collision between a detected transition and a flag-clear write. The transition only becomes visible inside the unit after the synchronizer stages, so the write has to be timed against that delay. The bench first sets a flag, then changes the pin level at a falling clock edge, and issues the clearing write exactly two falling edges later. At that point the detection and the write fall on the same rising edge. Mode changes while the pin is held steady are also driven, to show that the history register does not turn a reconfiguration into a false event.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ADDR_DED  = 2'd0,
        ADDR_SHR  = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/edgeirq_sync.sv
module edgeirq_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/edgeirq_detect.sv
module edgeirq_detect
    import edgeirq_pkg::*;
#(
    parameter int W = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [W-1:0]        lvl_i,
    input  logic [MODE_W*W-1:0] mode_i,
    output logic [W-1:0]        hit_o
);

    typedef struct packed {
        logic [W-1:0] hist;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [W-1:0] rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.hist = lvl_i;
        rise      = lvl_i & ~st_q.hist;
        fall      = ~lvl_i & st_q.hist;
        for (int i = 0; i < W; i++) begin
            case (edge_mode_e'(mode_i[MODE_W*i +: MODE_W]))
                MODE_RISE: hit_o[i] = rise[i];
                MODE_FALL: hit_o[i] = fall[i];
                MODE_BOTH: hit_o[i] = rise[i] | fall[i];
                default:   hit_o[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: the history follows the level whatever the mode
    a_r11_hist_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> st_q.hist == $past(lvl_i));

endmodule

// File: rtl/edgeirq_regs.sv
module edgeirq_regs
    import edgeirq_pkg::*;
#(
    parameter int NUM_DED = 3,
    parameter int NUM_SHR = 3,
    parameter int REG_W   = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [1:0]                addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    input  logic [NUM_SHR-1:0]        shr_hit_i,
    output logic [MODE_W*NUM_DED-1:0] ded_mode_o,
    output logic [MODE_W*NUM_SHR-1:0] shr_mode_o,
    output logic [REG_W-1:0]          rdata_o,
    output logic                      shr_evt_o
);

    localparam int DED_W = MODE_W * NUM_DED;
    localparam int SHR_W = MODE_W * NUM_SHR;

    typedef struct packed {
        logic [DED_W-1:0]   ded_pol;
        logic [SHR_W-1:0]   shr_pol;
        logic [NUM_SHR-1:0] flag;
        logic               shr_evt;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [NUM_SHR-1:0] clr_req;
    logic unused_hi;

    assign unused_hi = ^wdata_i[REG_W-1:SHR_W];

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < NUM_SHR; j++) begin
            clr_req[j] = wr_en_i && (addr_i == ADDR_FLAG) && !wdata_i[j];
        end
        if (wr_en_i && addr_i == ADDR_DED) st_d.ded_pol = wdata_i[DED_W-1:0];
        if (wr_en_i && addr_i == ADDR_SHR) st_d.shr_pol = wdata_i[SHR_W-1:0];
        for (int j = 0; j < NUM_SHR; j++) begin
            st_d.flag[j] = clr_req[j] ? 1'b0 : (st_q.flag[j] | shr_hit_i[j]);
        end
        st_d.shr_evt = |(st_d.flag & ~st_q.flag);

        case (reg_addr_e'(addr_i))
            ADDR_DED:  rdata_o = REG_W'(st_q.ded_pol);
            ADDR_SHR:  rdata_o = REG_W'(st_q.shr_pol);
            ADDR_FLAG: rdata_o = REG_W'(st_q.flag);
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ded_mode_o = st_q.ded_pol;
    assign shr_mode_o = st_q.shr_pol;
    assign shr_evt_o  = st_q.shr_evt;

    // R8: a shared pulse only follows a flag rising
    a_r8_evt_on_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shr_evt_o |-> (st_q.flag & ~$past(st_q.flag)) != '0);

    generate
        for (genvar j = 0; j < NUM_SHR; j++) begin : g_flag_chk
            // R7: a set flag survives unless a zero is written to it
            a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.flag[j] && !(wr_en_i && addr_i == ADDR_FLAG && !wdata_i[j]))
                |=> st_q.flag[j]);
            // R7: a flag rises only after a detected transition
            a_r7_flag_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(st_q.flag[j]) |-> $past(shr_hit_i[j]));
            // R10: a clearing write wins over a coincident transition
            a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i && addr_i == ADDR_FLAG && !wdata_i[j]) |=> !st_q.flag[j]);
        end
    endgenerate

endmodule

// File: rtl/edgeirq_unit.sv
module edgeirq_unit
    import edgeirq_pkg::*;
#(
    parameter int NUM_DED     = 3,
    parameter int NUM_SHR     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_DED+NUM_SHR-1:0] pin_i,
    input  logic                       wr_en_i,
    input  logic [1:0]                 addr_i,
    input  logic [REG_W-1:0]           wdata_i,
    output logic [REG_W-1:0]           rdata_o,
    output logic [NUM_DED-1:0]         ded_evt_o,
    output logic                       shr_evt_o
);

    localparam int NUM_PINS = NUM_DED + NUM_SHR;

    typedef struct packed {
        logic [NUM_DED-1:0] ded_evt;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_PINS-1:0]        lvl;
    logic [NUM_PINS-1:0]        hit;
    logic [MODE_W*NUM_DED-1:0]  ded_mode;
    logic [MODE_W*NUM_SHR-1:0]  shr_mode;

    edgeirq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (lvl)
    );

    edgeirq_detect #(.W(NUM_PINS)) detect_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl),
        .mode_i ({shr_mode, ded_mode}),
        .hit_o  (hit)
    );

    edgeirq_regs #(.NUM_DED(NUM_DED), .NUM_SHR(NUM_SHR), .REG_W(REG_W)) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .shr_hit_i  (hit[NUM_PINS-1:NUM_DED]),
        .ded_mode_o (ded_mode),
        .shr_mode_o (shr_mode),
        .rdata_o    (rdata_o),
        .shr_evt_o  (shr_evt_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ded_evt = hit[NUM_DED-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ded_evt_o = st_q.ded_evt;

    generate
        for (genvar i = 0; i < NUM_DED; i++) begin : g_ded_chk
            // R2: a disabled pin never raises its event
            a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ded_evt_o[i] |-> $past(ded_mode[MODE_W*i +: MODE_W]) != MODE_OFF);
            // R5: every event follows a real change of the synchronized level
            a_r5_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ded_evt_o[i] |-> $past(lvl[i]) != $past(lvl[i], 2));
        end
    endgenerate

endmodule

// File: tb/edgeirq_unit_tb.sv
module edgeirq_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pins = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] ded_evt;
    logic       shr_evt;

    int errors = 0;
    int checks = 0;
    int ded_cnt [3];
    int shr_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    edgeirq_unit dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pin_i     (pins),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .ded_evt_o (ded_evt),
        .shr_evt_o (shr_evt)
    );

    // Event counters sampled 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        for (int i = 0; i < 3; i++) if (ded_evt[i]) ded_cnt[i]++;
        if (shr_evt) shr_cnt++;
    end

    // vector: {pin[2:0], mode[1:0], start, end, expected}
    localparam logic [7:0] VEC [12] = '{
        {3'd0, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd0, 2'b01, 1'b1, 1'b0, 1'b0},
        {3'd1, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'b10, 1'b0, 1'b1, 1'b0},
        {3'd2, 2'b11, 1'b0, 1'b1, 1'b1},
        {3'd2, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd2, 2'b00, 1'b0, 1'b1, 1'b0},
        {3'd3, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd4, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd5, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd5, 2'b00, 1'b1, 1'b0, 1'b0},
        {3'd3, 2'b10, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic zero_cnt();
        for (int i = 0; i < 3; i++) ded_cnt[i] = 0;
        shr_cnt = 0;
    endtask

    initial begin
        logic [7:0] r;
        zero_cnt();
        wait_cyc(3);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            check("R1 reset register value", r, 0);
        end
        wait_cyc(1);
        check("R1 reset events", ded_cnt[0] + ded_cnt[1] + ded_cnt[2] + shr_cnt, 0);

        // R2: pins toggle while every mode is 00
        zero_cnt();
        pins = 6'h3F; wait_cyc(5);
        pins = 6'h00; wait_cyc(5);
        check("R2 no events with modes off", ded_cnt[0] + ded_cnt[1] + ded_cnt[2] + shr_cnt, 0);
        rd(2'd2, r);
        check("R2 no flags with modes off", r, 0);

        // Table walk: R2 R3 R4 R5 R7 R8
        foreach (VEC[v]) begin
            int pn, md, idx;
            pn = int'(VEC[v][7:5]);
            md = int'(VEC[v][4:3]);
            wr(2'd0, 8'h00); wr(2'd1, 8'h00);
            pins = '0; wait_cyc(4);
            wr(2'd2, 8'h00);
            pins[pn] = VEC[v][2]; wait_cyc(4);
            idx = (pn < 3) ? pn : pn - 3;
            wr((pn < 3) ? 2'd0 : 2'd1, 8'(md << (2 * idx)));
            wait_cyc(1);
            zero_cnt();
            pins[pn] = VEC[v][1];
            wait_cyc(6);
            if (pn < 3) begin
                check($sformatf("R3/R4/R5 vector %0d dedicated count", v),
                      ded_cnt[0] + ded_cnt[1] + ded_cnt[2], int'(VEC[v][0]));
            end else begin
                rd(2'd2, r);
                check($sformatf("R7 vector %0d flag", v), r, int'(VEC[v][0]) << idx);
                check($sformatf("R8 vector %0d shared count", v), shr_cnt, int'(VEC[v][0]));
            end
        end
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); pins = '0; wait_cyc(4); wr(2'd2, 8'h00);

        // R3: exact latency for pin 1 in rising mode
        wr(2'd0, 8'h04);
        wait_cyc(2);
        pins[1] = 1'b1;                       // set up before E1
        @(negedge clk); check("R3 no event after E1", ded_evt[1], 0);
        @(negedge clk); check("R3 no event after E2", ded_evt[1], 0);
        @(negedge clk); check("R3 event after E3", ded_evt[1], 1);
        @(negedge clk); check("R3 single-cycle pulse", ded_evt[1], 0);

        // R6: register layout and reserved bits
        wr(2'd0, 8'hFF); rd(2'd0, r); check("R6 dedicated modes bits 7:6 zero", r, 8'h3F);
        wr(2'd1, 8'hC5); rd(2'd1, r); check("R6 shared modes readback", r, 8'h05);
        wr(2'd3, 8'hFF); rd(2'd3, r); check("R6 address 3 reads zero", r, 0);
        wr(2'd2, 8'hFF); rd(2'd2, r); check("R6 flag write of ones sets nothing", r, 0);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); pins = '0; wait_cyc(4);

        // R8: one shared pulse per 0->1 flag change
        wr(2'd1, 8'h3F);
        wait_cyc(2); zero_cnt();
        pins[3] = 1'b1; wait_cyc(6);
        check("R8 first flag gives pulse", shr_cnt, 1);
        pins[3] = 1'b0; wait_cyc(6);
        check("R8 flag already set gives no pulse", shr_cnt, 1);
        pins[4] = 1'b1; wait_cyc(6);
        check("R8 second flag gives pulse", shr_cnt, 2);
        rd(2'd2, r); check("R7 flags accumulate", r, 8'h03);

        // R9: clear by writing zero, ones have no effect
        wr(2'd2, 8'hFD); rd(2'd2, r); check("R9 zero clears bit 1 only", r, 8'h01);
        wr(2'd2, 8'hFF); rd(2'd2, r); check("R9 writing ones keeps flag", r, 8'h01);

        // R10: transition detected in the cycle of the clearing write is lost
        zero_cnt();
        @(negedge clk); pins[3] = 1'b1;       // N0
        @(negedge clk);                        // N1
        @(negedge clk);                        // N2: write covers E3
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h00;
        @(negedge clk); wr_en = 1'b0;
        wait_cyc(5);
        rd(2'd2, r); check("R10 coincident edge lost, flag clear", r, 0);
        check("R10 no shared pulse", shr_cnt, 0);
        wr(2'd1, 8'h00); pins = '0; wait_cyc(4); wr(2'd2, 8'h00);

        // R11: mode changes with a steady pin
        wr(2'd0, 8'h00);
        pins[2] = 1'b1; wait_cyc(6);
        zero_cnt();
        wr(2'd0, 8'h10); wait_cyc(5);
        check("R11 enabling rise on a high pin is silent", ded_cnt[2], 0);
        wr(2'd0, 8'h20); wait_cyc(5);
        check("R11 switching to fall is silent", ded_cnt[2], 0);
        pins[2] = 1'b0; wait_cyc(6);
        check("R11 real fall still detected", ded_cnt[2], 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule